// File: doc/BRIEF.md
# Burst-of-Two Separate-Port DDR SRAM Core

This block is a small synthesizable model of a static RAM with separate data-in and data-out buses and a fixed burst length of two. The double-data-rate interface is modelled as one beat per cycle of a single fast clock. The core tracks internally whether the current beat is even or odd, and it reports this on `cmd_slot`. A read port and a write port, each with its own address, are sampled only on even beats. Both may carry a request on the same beat.

Each stored word is twice as wide as the I/O bus. A write supplies its two data beats on the command beat and on the beat that follows. Each beat carries its own per-byte mask. The core gathers the two halves and writes the whole word in one array access. A read fetches one double-width word and returns it as two consecutive output beats, lower half first. The read path sees a write from the same slot, so it always returns coherent data.

The bus width is set as a count of 9-bit bytes. The address width sets the number of double-width words. Reset clears the pipelines but leaves the stored contents intact.

Top module: `sio_b2_sram`

## Requirements
- R1: A write request sampled on an even beat takes its first data beat from that beat and its second from the next beat. Both halves are stored at the write address in a single array write, with the first beat in the lower half (bits DW-1..0) and the second in the upper half (bits 2*DW-1..DW).
- R2: A read request sampled on even beat n drives the lower half of the addressed word on `dout` during the cycle after edge n+2, and the upper half during the cycle after edge n+3.
- R3: `dout_valid` is high for exactly the two output beats of each read and low otherwise. `dout` is zero whenever `dout_valid` is low.
- R4: `din_mask[b]` high on a data beat keeps byte b of that beat unchanged, where byte b is bits 9b+8..9b of the beat. Low writes that byte. Each beat's mask is applied independently.
- R5: `cmd_slot` is high on even beats and alternates every cycle. The first beat after reset is even. Read or write requests presented on odd beats are ignored.
- R6: A read and a write to different addresses in the same slot are both carried out.
- R7: A read in the same slot as a write to the same address returns the merged data: new bytes where unmasked, old bytes where masked. A read in an earlier slot returns the old word.
- R8: Reset drops any read in flight, holds `dout_valid` low and `dout` zero, and leaves the array contents unchanged.
- R9: The array holds 2^AW independent words of 2*DW bits. Every address keeps its own contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one data beat per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipelines |
| rd_req | input | 1 | Read request, honoured on even beats only |
| rd_addr | input | AW | Word address of the read |
| wr_req | input | 1 | Write request, honoured on even beats only |
| wr_addr | input | AW | Word address of the write |
| din | input | 9*BYTES | Write data beat |
| din_mask | input | BYTES | Per-byte keep mask for the current data beat (1 = keep old byte) |
| cmd_slot | output | 1 | High when the current beat may carry a command |
| dout | output | 9*BYTES | Read data beat |
| dout_valid | output | 1 | High while `dout` carries read data |

## Verification
On every cycle, the assertions check the timing skeleton. Array commits fall only on odd beats and follow an accepted write. Every accepted read produces a valid pair exactly three and four cycles later. Valid beats come only in such pairs, and reset keeps the output quiet. Data content is shown only by the bench's scenarios. These include the byte-mask merge on each beat, the lower/upper ordering of the halves, and read-after-write coherence in the same slot. They also cover the rejection of odd-beat requests and the survival of the stored words across a reset. The bench checks each of these against a word-level model it keeps itself.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam int BYTE_W = 9;

   typedef enum logic {
      SLOT_EVEN = 1'b0,
      SLOT_ODD  = 1'b1
   } slot_e;
endpackage

// File: rtl/sio_write_gather.sv
// Collects the two data beats of one write and presents them as a
// double-width commit during the second beat.
module sio_write_gather #(
   parameter int DW = 18,
   parameter int NB = 2,
   parameter int AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     din,
   input  logic [NB-1:0]     mask,
   output logic              commit,
   output logic [AW-1:0]     commit_addr,
   output logic [2*DW-1:0]   commit_data,
   output logic [2*NB-1:0]   commit_mask
);
   logic          stg_v;
   logic [AW-1:0] stg_a;
   logic [DW-1:0] stg_d;
   logic [NB-1:0] stg_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_v <= 1'b0;
      else        stg_v <= take;
   end

   always_ff @(posedge clk) begin
      if (take) begin
         stg_a <= addr;
         stg_d <= din;
         stg_m <= mask;
      end
   end

   // second beat joins the staged first beat in the upper half
   assign commit      = stg_v;
   assign commit_addr = stg_a;
   assign commit_data = {din, stg_d};
   assign commit_mask = {mask, stg_m};
endmodule

// File: rtl/sio_word_array.sv
// Double-width storage with per-byte merge and a same-cycle bypass for
// the read port.
module sio_word_array
   import sio_pkg::*;
#(
   parameter int DW = 18,
   parameter int NB = 2,
   parameter int AW = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [2*DW-1:0]   wdata,
   input  logic [2*NB-1:0]   wmask,
   input  logic [AW-1:0]     raddr,
   output logic [2*DW-1:0]   rdata
);
   localparam int DEPTH = 1 << AW;
   localparam int WW    = 2 * DW;
   localparam int LANES = 2 * NB;

   logic [WW-1:0] mem [DEPTH];
   logic [WW-1:0] old_word;
   logic [WW-1:0] merged;

   assign old_word = mem[waddr];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*BYTE_W +: BYTE_W] = wmask[g] ? old_word[g*BYTE_W +: BYTE_W]
                                                   : wdata[g*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= merged;
   end

   // a read on the commit cycle sees the merged word
   assign rdata = (we && (waddr == raddr)) ? merged : mem[raddr];
endmodule

// File: rtl/sio_read_mux.sv
// Read pipeline: address stage, word fetch stage, then two output beats.
module sio_read_mux #(
   parameter int DW = 18,
   parameter int AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [AW-1:0]     addr,
   output logic [AW-1:0]     fetch_addr,
   input  logic [2*DW-1:0]   word,
   output logic [DW-1:0]     dout,
   output logic              dout_valid
);
   logic           s1_v, s2_v, s3_v;
   logic [AW-1:0]  s1_a;
   logic [2*DW-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v       <= 1'b0;
         s2_v       <= 1'b0;
         s3_v       <= 1'b0;
         dout       <= '0;
         dout_valid <= 1'b0;
      end else begin
         s1_v <= take;
         s2_v <= s1_v;
         s3_v <= s2_v;
         if (s2_v) begin
            dout       <= word_q[DW-1:0];
            dout_valid <= 1'b1;
         end else if (s3_v) begin
            dout       <= word_q[2*DW-1:DW];
            dout_valid <= 1'b1;
         end else begin
            dout       <= '0;
            dout_valid <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) s1_a   <= addr;
      if (s1_v) word_q <= word;
   end

   assign fetch_addr = s1_a;
endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram
   import sio_pkg::*;
#(
   parameter int BYTES = 2,
   parameter int AW    = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_req,
   input  logic [AW-1:0]           rd_addr,
   input  logic                    wr_req,
   input  logic [AW-1:0]           wr_addr,
   input  logic [BYTE_W*BYTES-1:0] din,
   input  logic [BYTES-1:0]        din_mask,
   output logic                    cmd_slot,
   output logic [BYTE_W*BYTES-1:0] dout,
   output logic                    dout_valid
);
   localparam int DW = BYTE_W * BYTES;
   localparam int WW = 2 * DW;

   if (BYTES < 1) begin : g_bad_bytes
      $error("sio_b2_sram: BYTES must be at least 1");
   end
   if (AW < 1 || AW > 20) begin : g_bad_aw
      $error("sio_b2_sram: AW must lie in 1..20");
   end

   slot_e slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                slot <= SLOT_EVEN;
      else if (slot == SLOT_EVEN) slot <= SLOT_ODD;
      else                       slot <= SLOT_EVEN;
   end

   assign cmd_slot = (slot == SLOT_EVEN);

   logic            wr_take, rd_take;
   logic            wr_commit;
   logic [AW-1:0]   commit_addr, fetch_addr;
   logic [WW-1:0]   commit_data, fetch_word;
   logic [2*BYTES-1:0] commit_mask;

   assign wr_take = wr_req && cmd_slot;
   assign rd_take = rd_req && cmd_slot;

   sio_write_gather #(.DW(DW), .NB(BYTES), .AW(AW)) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (wr_take),
      .addr        (wr_addr),
      .din         (din),
      .mask        (din_mask),
      .commit      (wr_commit),
      .commit_addr (commit_addr),
      .commit_data (commit_data),
      .commit_mask (commit_mask)
   );

   sio_word_array #(.DW(DW), .NB(BYTES), .AW(AW)) u_array (
      .clk   (clk),
      .we    (wr_commit),
      .waddr (commit_addr),
      .wdata (commit_data),
      .wmask (commit_mask),
      .raddr (fetch_addr),
      .rdata (fetch_word)
   );

   sio_read_mux #(.DW(DW), .AW(AW)) u_rmux (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (rd_take),
      .addr       (rd_addr),
      .fetch_addr (fetch_addr),
      .word       (fetch_word),
      .dout       (dout),
      .dout_valid (dout_valid)
   );
endmodule

// File: rtl/sio_b2_sram_chk.sv
module sio_b2_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_req,
   input logic wr_req,
   input logic cmd_slot,
   input logic wr_commit,
   input logic dout_valid
);
   // R5
   commit_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> !cmd_slot);

   // R1
   commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(wr_req && cmd_slot));

   // R2
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cmd_slot) |-> ##3 dout_valid ##1 dout_valid);

   // R3
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !cmd_slot) |-> $past(rd_req && cmd_slot, 3));

   // R3
   valid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !cmd_slot) |=> dout_valid);

   // R3
   valid_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && cmd_slot) |-> $past(dout_valid));

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !dout_valid);
endmodule

bind sio_b2_sram sio_b2_sram_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_req     (rd_req),
   .wr_req     (wr_req),
   .cmd_slot   (cmd_slot),
   .wr_commit  (wr_commit),
   .dout_valid (dout_valid)
);

// File: tb/tb_sio_b2_sram.sv
module tb_sio_b2_sram;
   localparam int BYTES = 2;
   localparam int AW    = 4;
   localparam int DW    = 9 * BYTES;
   localparam int WW    = 2 * DW;
   localparam int DEPTH = 1 << AW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rd_req = 1'b0, wr_req = 1'b0;
   logic [AW-1:0]    rd_addr = '0, wr_addr = '0;
   logic [DW-1:0]    din = '0;
   logic [BYTES-1:0] din_mask = '0;
   logic             cmd_slot;
   logic [DW-1:0]    dout;
   logic             dout_valid;

   sio_b2_sram #(.BYTES(BYTES), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .wr_req(wr_req), .wr_addr(wr_addr),
      .din(din), .din_mask(din_mask),
      .cmd_slot(cmd_slot), .dout(dout), .dout_valid(dout_valid)
   );

   always #5 clk = ~clk;

   int unsigned tcyc = 0;
   always @(posedge clk) tcyc <= tcyc + 1;

   int errs = 0, checks = 0;
   bit done = 0, mon_en = 0;
   logic [WW-1:0] mdl [DEPTH];
   logic          exp_v [8];
   logic [DW-1:0] exp_d [8];

   function automatic logic [DW-1:0] pat(int a, int k);
      return DW'(a * 4099 + k * 613 + 77);
   endfunction

   function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [DW-1:0] d0,
                                           logic [1:0] m0, logic [DW-1:0] d1, logic [1:0] m1);
      logic [WW-1:0] r;
      r = old;
      for (int b = 0; b < BYTES; b++) begin
         if (!m0[b]) r[b*9 +: 9]      = d0[b*9 +: 9];
         if (!m1[b]) r[DW + b*9 +: 9] = d1[b*9 +: 9];
      end
      return r;
   endfunction

   // R2 R3: output beats compared against the schedule every cycle
   always @(negedge clk) begin
      if (mon_en) begin
         int idx;
         idx = int'(tcyc % 8);
         checks++;
         if (dout_valid !== exp_v[idx] || (exp_v[idx] && dout !== exp_d[idx]) ||
             (!exp_v[idx] && dout !== '0)) begin
            errs++;
            $display("FAIL R2/R3 cyc=%0d valid=%0b data=%h expected valid=%0b data=%h",
                     tcyc, dout_valid, dout, exp_v[idx], exp_v[idx] ? exp_d[idx] : '0);
         end
         exp_v[idx] = 1'b0;
      end
   end

   // one command slot: even beat then odd beat
   task automatic slot(bit rd, int ra, bit wr, int wa, logic [DW-1:0] d0, logic [1:0] m0,
                       logic [DW-1:0] d1, logic [1:0] m1, bit junk);
      @(negedge clk);
      checks++;
      if (cmd_slot !== 1'b1) begin  // R5
         errs++;
         $display("FAIL R5 cmd_slot=%0b expected 1", cmd_slot);
      end
      rd_req = rd; rd_addr = AW'(ra); wr_req = wr; wr_addr = AW'(wa);
      din = d0; din_mask = m0;
      if (wr) mdl[wa] = merge(mdl[wa], d0, m0, d1, m1);  // R7: same-slot read sees it
      if (rd) begin
         exp_v[(tcyc + 3) % 8] = 1'b1; exp_d[(tcyc + 3) % 8] = mdl[ra][DW-1:0];
         exp_v[(tcyc + 4) % 8] = 1'b1; exp_d[(tcyc + 4) % 8] = mdl[ra][WW-1:DW];
      end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (cmd_slot !== 1'b0) begin  // R5
         errs++;
         $display("FAIL R5 cmd_slot=%0b expected 0", cmd_slot);
      end
      // R5: odd-beat requests aimed at another address must be ignored
      rd_req = junk; wr_req = junk;
      rd_addr = AW'(ra + 5); wr_addr = AW'(wa + 3);
      din = d1; din_mask = m1;
      @(posedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; mon_en = 0;
      rd_req = 0; wr_req = 0;
      for (int i = 0; i < 8; i++) exp_v[i] = 1'b0;
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (dout_valid !== 1'b0 || dout !== '0) begin  // R8
            errs++;
            $display("FAIL R8 valid=%0b data=%h expected 0/0 in reset", dout_valid, dout);
         end
      end
      rst_n = 1'b1; mon_en = 1;
      @(posedge clk);
      @(posedge clk);
   endtask

   task automatic read_all();
      for (int a = 0; a < DEPTH; a++) slot(1, a, 0, 0, '0, 2'b00, '0, 2'b00, 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
      do_reset();
      // R1 R9: full writes to every address
      for (int a = 0; a < DEPTH; a++) slot(0, 0, 1, a, pat(a, 0), 2'b00, pat(a, 1), 2'b00, 0);
      read_all();  // R2 R9
      // R4: every mask pair on both beats
      for (int m = 0; m < 16; m++)
         slot(0, 0, 1, m, pat(m, m + 2), 2'(m), pat(m, m + 5), 2'(m >> 2), 0);
      read_all();
      // R7: same-slot read and write of one address
      for (int a = 0; a < DEPTH; a++)
         slot(1, a, 1, a, pat(a, 40), 2'(a), pat(a, 41), 2'(a >> 1), 0);
      // R6: read and write to different addresses, with idle gaps
      for (int a = 0; a < DEPTH; a++) begin
         slot(1, a, 1, (a + 7) % DEPTH, pat(a, 50), 2'b00, pat(a, 51), 2'b10, 0);
         if (a % 4 == 0) slot(0, 0, 0, 0, '0, 2'b00, '0, 2'b00, 0);
      end
      // R7: read issued one slot before a write returns the old word
      slot(1, 2, 0, 0, '0, 2'b00, '0, 2'b00, 0);
      slot(0, 0, 1, 2, pat(2, 60), 2'b00, pat(2, 61), 2'b00, 0);
      slot(1, 2, 0, 0, '0, 2'b00, '0, 2'b00, 0);
      // R5: odd-beat requests with real ones and without
      for (int a = 0; a < 8; a++) begin
         slot(0, 0, 1, a, pat(a, 70), 2'b00, pat(a, 71), 2'b00, 1);
         slot(1, a, 0, 0, '0, 2'b00, pat(a, 72), 2'b00, 1);
         slot(0, 0, 0, 0, pat(a, 73), 2'b00, pat(a, 74), 2'b00, 1);
      end
      read_all();
      // R8: reset drops an in-flight read and keeps the array
      slot(1, 3, 0, 0, '0, 2'b00, '0, 2'b00, 0);
      do_reset();
      read_all();
      repeat (4) slot(0, 0, 0, 0, '0, 2'b00, '0, 2'b00, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule